// File: doc/BRIEF.md
# Per-Bin Complex Matrix MAC Engine

This block takes several frequency-domain sample streams and turns them into per-bin partial products for a set of destination channels. Each input stream carries two source radio channels, interleaved item by item. For each FFT bin the engine joins one item pair from every stream and splits the pairs back into the separate source channels. It then computes, for every destination channel, the complex dot product of all source samples with that bin's column of a coefficient matrix. The results leave on partial-product lanes. Each lane carries two destination channels in alternation.

Samples and coefficients are complex values with 16-bit I and 16-bit Q. Each complex product is scaled back by 15 bits with rounding. The sum for a destination saturates to 16 bits per component. The coefficients sit in two banks. One bank is live and feeds the multipliers. The other is a shadow bank that can be rewritten at any time through a single write port. A bank swap can be requested at any moment, but it takes effect only at the first bin of a new frame. A reload therefore never mixes two coefficient sets within one frame.

Top module: `bin_matrix_mac`

## Requirements
- R1: Stream s carries source channel 2s in the first item of each bin and source channel 2s+1 in the second item, both with the same bin index. A sample is packed with I in bits [31:16] and Q in bits [15:0]. Stream s occupies in_data_i[32s+31:32s] and in_bin_i[4s+3:4s].
- R2: For bin b and destination d the result is the sum over sources s of x_s · c[b][s][d]. The coefficients come from the live bank. A coefficient is written at address (b·8 + s)·4 + d through cw_addr_i, packed like a sample.
- R3: Each complex product component (re = xr·cr − xi·ci, im = xr·ci + xi·cr) is scaled to (p + 16384) >>> 15 before it is summed.
- R4: Each summed component saturates to the range −32768..32767.
- R5: The clock edge that accepts the second item of a bin starts an output pair. out_valid_o is high for the next two cycles. In the first cycle out_odd_o is 0 and lane k carries destination 2k. In the second cycle out_odd_o is 1 and lane k carries destination 2k+1. out_bin_o holds the bin index throughout the pair.
- R6: Items are taken from the streams, with every in_ready_o high, only when all streams are valid, all carry radio data, and all show the same bin. Otherwise no stream with good data is taken, except as stated in R7.
- R7: Suppose all streams are valid with radio data but the bins differ. Then every stream whose bin differs from stream 0's bin has its item taken and discarded. Stream 0 waits. The item phase does not advance.
- R8: An item whose in_rx_i bit is 0 (not radio data) is taken and discarded in the same cycle. err_o is high in the next cycle.
- R9: Coefficient writes change only the shadow bank. Outputs computed from the live bank are unaffected.
- R10: A swap request takes effect when the first item of bin 0 is accepted, provided the request came at least one cycle earlier. The new bank then covers that whole frame. A bank swap never happens at any other point.
- R11: After reset out_valid_o and err_o are 0, bank 0 is live, no swap is pending, and the next item accepted is the first item of a bin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 4 | Per-stream item valid |
| in_ready_o | output | 4 | Per-stream item taken |
| in_rx_i | input | 4 | Per-stream flag: item is radio sample data |
| in_bin_i | input | 16 | Per-stream bin index, 4 bits each |
| in_data_i | input | 128 | Per-stream complex sample, 32 bits each |
| cw_en_i | input | 1 | Coefficient write strobe (shadow bank) |
| cw_addr_i | input | 9 | Coefficient address (bin·8+src)·4+dst |
| cw_data_i | input | 32 | Coefficient value, I high, Q low |
| swap_req_i | input | 1 | Request a bank swap at the next frame start |
| out_valid_o | output | 1 | Partial-product item valid |
| out_odd_o | output | 1 | 0: even destinations, 1: odd destinations |
| out_bin_o | output | 4 | Bin index of the output pair |
| out_data_o | output | 64 | Per-lane complex partial product, 32 bits each |
| err_o | output | 1 | A non-radio item was discarded in the previous cycle |

## Verification
On every cycle the assertions check the following. Every output pair is even then odd with a steady bin index. A pair only ever follows a bin's second-item acceptance. A ready never appears without a valid. Stream 0 is never dropped on a bin mismatch. A discarded non-radio item always raises the error flag. The live bank only changes on a bin-0 first-item acceptance. Only the bench scenarios can show that the values are correct, using coefficients loaded by the bench and checked against its own arithmetic. That covers rounding, saturation, the source deinterleave order, shadow writes and swap requests made mid-frame, and the recovery of the item phase after discarded and mismatched items.

// File: rtl/bmm_pkg.sv
package bmm_pkg;
  localparam int SAMP_W = 16;

  typedef struct packed {
    logic signed [SAMP_W-1:0] re;
    logic signed [SAMP_W-1:0] im;
  } cplx_t;

  // round-half-up then drop 15 fraction bits
  function automatic logic signed [31:0] rnd15(input logic signed [32:0] p);
    logic signed [32:0] t;
    t = (p + 33'sd16384) >>> 15;
    return t[31:0];
  endfunction

  function automatic logic signed [SAMP_W-1:0] sat16(input logic signed [31:0] v);
    if (v > 32'sd32767)       return 16'sh7fff;
    else if (v < -32'sd32768) return 16'sh8000;
    else                      return v[SAMP_W-1:0];
  endfunction
endpackage

// File: rtl/bmm_join.sv
module bmm_join #(
  parameter int N_STR = 4,
  parameter int BIN_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_STR-1:0]       valid_i,
  input  logic [N_STR-1:0]       rx_i,
  input  logic [N_STR*BIN_W-1:0] bin_i,
  output logic [N_STR-1:0]       ready_o,
  output logic                   fire_o,
  output logic                   phase_o,
  output logic [BIN_W-1:0]       bin_o,
  output logic                   err_o
);
  logic [N_STR-1:0] bad, ok, same;
  logic all_ok, match;
  logic phase_q, err_q;

  for (genvar s = 0; s < N_STR; s++) begin : g_str
    assign bad[s]     = valid_i[s] & ~rx_i[s];
    assign ok[s]      = valid_i[s] & rx_i[s];
    assign same[s]    = bin_i[s*BIN_W +: BIN_W] == bin_i[BIN_W-1:0];
    assign ready_o[s] = fire_o | bad[s] | (all_ok & ~same[s]);
  end

  assign all_ok  = &ok;
  assign match   = &same;
  assign fire_o  = all_ok & match;
  assign phase_o = phase_q;
  assign bin_o   = bin_i[BIN_W-1:0];
  assign err_o   = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= |bad;
      if (fire_o) phase_q <= ~phase_q;
    end
  end

  p_ready_needs_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o & ~valid_i) == '0);
  p_ref_stream_waits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_ok && !match) |-> !ready_o[0]);
  p_err_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bad) |=> err_o);
endmodule

// File: rtl/bmm_coef_bank.sv
module bmm_coef_bank import bmm_pkg::*; #(
  parameter int FFT_SIZE = 16,
  parameter int N_SRC    = 8,
  parameter int N_DST    = 4,
  localparam int PER_BIN = N_SRC * N_DST,
  localparam int DEPTH   = FFT_SIZE * PER_BIN,
  localparam int AW      = $clog2(DEPTH),
  localparam int BIN_W   = $clog2(FFT_SIZE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  cplx_t            wdata_i,
  input  logic             swap_req_i,
  input  logic             frame_start_i,
  input  logic [BIN_W-1:0] rbin_i,
  output cplx_t            coef_o [PER_BIN]
);
  cplx_t bank0 [DEPTH];
  cplx_t bank1 [DEPTH];
  logic  live_q, pend_q, apply;

  assign apply = frame_start_i & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~apply) | swap_req_i;
      if (apply) live_q <= ~live_q;
    end
  end

  // writes always target the bank not in use this cycle
  always_ff @(posedge clk_i) begin
    if (we_i && live_q)  bank0[waddr_i] <= wdata_i;
    if (we_i && !live_q) bank1[waddr_i] <= wdata_i;
  end

  for (genvar i = 0; i < PER_BIN; i++) begin : g_rd
    logic [AW-1:0] ra;
    assign ra        = AW'(rbin_i) * AW'(PER_BIN) + AW'(i);
    assign coef_o[i] = live_q ? bank1[ra] : bank0[ra];
  end

  p_swap_at_frame_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(live_q) |-> $past(frame_start_i));
endmodule

// File: rtl/bmm_dot_lane.sv
module bmm_dot_lane import bmm_pkg::*; #(
  parameter int N_SRC = 8
) (
  input  cplx_t src_i  [N_SRC],
  input  cplx_t coef_i [N_SRC],
  output cplx_t y_o
);
  logic signed [31:0] acc_r, acc_i;
  logic signed [32:0] ar, ai, br, bi;

  always_comb begin
    acc_r = '0;
    acc_i = '0;
    ar = '0; ai = '0; br = '0; bi = '0;
    for (int s = 0; s < N_SRC; s++) begin
      ar = src_i[s].re;
      ai = src_i[s].im;
      br = coef_i[s].re;
      bi = coef_i[s].im;
      acc_r = acc_r + rnd15(ar * br - ai * bi);
      acc_i = acc_i + rnd15(ar * bi + ai * br);
    end
    y_o.re = sat16(acc_r);
    y_o.im = sat16(acc_i);
  end
endmodule

// File: rtl/bin_matrix_mac.sv
module bin_matrix_mac import bmm_pkg::*; #(
  parameter int N_STR    = 4,
  parameter int N_DST    = 4,
  parameter int FFT_SIZE = 16
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [N_STR-1:0]                       in_valid_i,
  output logic [N_STR-1:0]                       in_ready_o,
  input  logic [N_STR-1:0]                       in_rx_i,
  input  logic [N_STR*$clog2(FFT_SIZE)-1:0]      in_bin_i,
  input  logic [N_STR*32-1:0]                    in_data_i,
  input  logic                                   cw_en_i,
  input  logic [$clog2(FFT_SIZE*N_STR*2*N_DST)-1:0] cw_addr_i,
  input  logic [31:0]                            cw_data_i,
  input  logic                                   swap_req_i,
  output logic                                   out_valid_o,
  output logic                                   out_odd_o,
  output logic [$clog2(FFT_SIZE)-1:0]            out_bin_o,
  output logic [(N_DST/2)*32-1:0]                out_data_o,
  output logic                                   err_o
);
  localparam int N_SRC   = 2 * N_STR;
  localparam int N_OUT   = N_DST / 2;
  localparam int BIN_W   = $clog2(FFT_SIZE);
  localparam int PER_BIN = N_SRC * N_DST;

  logic             fire, phase, frame_start;
  logic [BIN_W-1:0] bin;
  cplx_t            coefs [PER_BIN];
  cplx_t            col   [N_DST][N_SRC];
  cplx_t            src   [N_SRC];
  cplx_t            lane_y [N_DST];
  cplx_t            even_q [N_STR];
  cplx_t            res_q  [N_DST];
  logic             out_v_q, out_odd_q;
  logic [BIN_W-1:0] out_bin_q;

  bmm_join #(.N_STR(N_STR), .BIN_W(BIN_W)) join_i (
    .clk_i, .rst_ni,
    .valid_i(in_valid_i), .rx_i(in_rx_i), .bin_i(in_bin_i),
    .ready_o(in_ready_o), .fire_o(fire), .phase_o(phase), .bin_o(bin), .err_o(err_o)
  );

  assign frame_start = fire & ~phase & (bin == '0);

  bmm_coef_bank #(.FFT_SIZE(FFT_SIZE), .N_SRC(N_SRC), .N_DST(N_DST)) bank_i (
    .clk_i, .rst_ni,
    .we_i(cw_en_i), .waddr_i(cw_addr_i), .wdata_i(cplx_t'(cw_data_i)),
    .swap_req_i, .frame_start_i(frame_start), .rbin_i(bin), .coef_o(coefs)
  );

  // even sources come from the capture register, odd ones straight from the streams
  always_comb begin
    for (int s = 0; s < N_STR; s++) begin
      src[2*s]   = even_q[s];
      src[2*s+1] = cplx_t'(in_data_i[32*s +: 32]);
    end
    for (int d = 0; d < N_DST; d++)
      for (int s = 0; s < N_SRC; s++)
        col[d][s] = coefs[s*N_DST + d];
  end

  for (genvar d = 0; d < N_DST; d++) begin : g_lane
    bmm_dot_lane #(.N_SRC(N_SRC)) lane_i (.src_i(src), .coef_i(col[d]), .y_o(lane_y[d]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < N_STR; s++) even_q[s] <= '0;
      for (int d = 0; d < N_DST; d++) res_q[d] <= '0;
      out_v_q   <= 1'b0;
      out_odd_q <= 1'b0;
      out_bin_q <= '0;
    end else begin
      if (fire && !phase)
        for (int s = 0; s < N_STR; s++) even_q[s] <= cplx_t'(in_data_i[32*s +: 32]);
      if (fire && phase) begin
        for (int d = 0; d < N_DST; d++) res_q[d] <= lane_y[d];
        out_v_q   <= 1'b1;
        out_odd_q <= 1'b0;
        out_bin_q <= bin;
      end else if (out_v_q && !out_odd_q) begin
        out_odd_q <= 1'b1;
      end else begin
        out_v_q   <= 1'b0;
        out_odd_q <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assign out_data_o[32*k +: 32] = out_odd_q ? res_q[2*k+1] : res_q[2*k];
  end
  assign out_valid_o = out_v_q;
  assign out_odd_o   = out_odd_q;
  assign out_bin_o   = out_bin_q;

  p_pair_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_odd_o) |=> (out_valid_o && out_odd_o && $stable(out_bin_o)));
  p_pair_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_odd_o) |-> $past(fire && phase));
endmodule

// File: tb/bin_matrix_mac_tb_top.sv
module bin_matrix_mac_tb_top;
  localparam int N_STR = 4, N_DST = 4, FFT = 16, N_SRC = 8, N_OUT = 2;

  logic clk = 0, rst_ni = 0;
  logic [3:0] in_valid = '0, in_ready, in_rx = '0;
  logic [15:0] in_bin = '0;
  logic [127:0] in_data = '0;
  logic cw_en = 0, swap_req = 0;
  logic [8:0] cw_addr = '0;
  logic [31:0] cw_data = '0;
  logic out_valid, out_odd, err;
  logic [3:0] out_bin;
  logic [63:0] out_data;

  always #2 clk = ~clk;

  bin_matrix_mac dut_i (
    .clk_i(clk), .rst_ni, .in_valid_i(in_valid), .in_ready_o(in_ready), .in_rx_i(in_rx),
    .in_bin_i(in_bin), .in_data_i(in_data), .cw_en_i(cw_en), .cw_addr_i(cw_addr),
    .cw_data_i(cw_data), .swap_req_i(swap_req), .out_valid_o(out_valid), .out_odd_o(out_odd),
    .out_bin_o(out_bin), .out_data_o(out_data), .err_o(err)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, mon_n = 0;
  bit done = 0;
  logic [63:0] mon_data [256];
  int mon_bin [256];
  int mon_odd [256];

  always @(negedge clk) if (rst_ni && out_valid && mon_n < 256) begin
    mon_data[mon_n] = out_data;
    mon_bin[mon_n]  = int'(out_bin);
    mon_odd[mon_n]  = int'(out_odd);
    mon_n++;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] samp(int f, int b, int ch);
    int r, i;
    if (f == 3) begin r = 32767; i = 0; end
    else begin
      r = ((f*37 + b*11 + ch*5) % 200 - 100) * 150;
      i = ((f*13 + b*7 + ch*3) % 180 - 90) * 170;
    end
    return {r[15:0], i[15:0]};
  endfunction

  function automatic logic [31:0] coef(int set, int b, int s, int d);
    int r, i;
    if (set == 0) begin
      r = ((b*3 + s*7 + d*13) % 60 - 30) * 500;
      i = ((b*5 + s + d*3) % 40 - 20) * 400;
    end else begin
      r = (b < 8 ? 18000 : -18000) + s*100 - d*50;
      i = (s*d*37) % 300 - 150;
    end
    return {r[15:0], i[15:0]};
  endfunction

  function automatic longint sat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // expected partial product for one destination, from R2 R3 R4
  function automatic logic [31:0] expect_pp(int f, int b, int d, int set);
    longint ar = 0, ai = 0;
    for (int s = 0; s < N_SRC; s++) begin
      logic [31:0] x, c;
      longint xr, xi, cr, ci;
      x = samp(f, b, s);
      c = coef(set, b, s, d);
      xr = longint'($signed(x[31:16])); xi = longint'($signed(x[15:0]));
      cr = longint'($signed(c[31:16])); ci = longint'($signed(c[15:0]));
      ar += (xr*cr - xi*ci + 16384) >>> 15;
      ai += (xr*ci + xi*cr + 16384) >>> 15;
    end
    ar = sat(ar); ai = sat(ai);
    return {ar[15:0], ai[15:0]};
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic send_bins(int f, int b0, int b1);
    for (int b = b0; b <= b1; b++)
      for (int p = 0; p < 2; p++) begin
        in_valid = '1; in_rx = '1;
        for (int s = 0; s < N_STR; s++) begin
          in_bin[4*s +: 4] = 4'(b);
          in_data[32*s +: 32] = samp(f, b, 2*s + p);  // R1 ordering
        end
        step();
      end
    in_valid = '0;
  endtask

  task automatic load_set(int set);
    for (int b = 0; b < FFT; b++)
      for (int s = 0; s < N_SRC; s++)
        for (int d = 0; d < N_DST; d++) begin
          cw_en = 1; cw_addr = 9'((b*N_SRC + s)*N_DST + d); cw_data = coef(set, b, s, d);
          step();
        end
    cw_en = 0;
  endtask

  task automatic pulse_swap();
    swap_req = 1; step(); swap_req = 0;
  endtask

  task automatic drain();
    repeat (4) step();
  endtask

  task automatic check_frame(int f, int set, int base, string tag, output int sat_hits);
    sat_hits = 0;
    chk({tag, " R5 item count"}, mon_n, base + 2*FFT);
    for (int b = 0; b < FFT; b++)
      for (int o = 0; o < 2; o++) begin
        int idx = base + 2*b + o;
        chk({tag, " R5 bin/odd"}, mon_bin[idx]*2 + mon_odd[idx], b*2 + o);
        for (int k = 0; k < N_OUT; k++) begin
          logic [31:0] e = expect_pp(f, b, 2*k + o, set);
          if (e[31:16] == 16'h7fff || e[31:16] == 16'h8000) sat_hits++;
          chk({tag, " R1 R2 R3 data"}, longint'(mon_data[idx][32*k +: 32]), longint'(e));
        end
      end
  endtask

  task automatic t_reset();
    rst_ni = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 out_valid after reset", out_valid, 0);
    chk("R11 err after reset", err, 0);
    chk("R11 ready after reset", in_ready, 0);
    #1; @(posedge clk); #1; rst_ni = 1;
  endtask

  task automatic t_frames();
    int h;
    load_set(0);
    pulse_swap();
    // frame 1: live set A; set B written and swap requested mid-frame (R9 R10)
    send_bins(1, 0, 5);
    load_set(1);
    send_bins(1, 6, 8);
    pulse_swap();
    send_bins(1, 9, 15);
    drain();
    check_frame(1, 0, 0, "R9 R10 frame1", h);
    send_bins(2, 0, 15);
    drain();
    check_frame(2, 1, 32, "R10 frame2", h);
    send_bins(3, 0, 15);
    drain();
    check_frame(3, 1, 64, "R4 frame3", h);
    chk("R4 saturated results seen", h > 0, 1);
  endtask

  task automatic t_bad_item();
    int n0 = mon_n;
    in_valid = '1; in_rx = 4'b1011; in_bin = '0;
    @(negedge clk);
    chk("R8 ready on non-radio item", in_ready, 4'b0100);
    step(); in_valid = '0; in_rx = '1;
    @(negedge clk);
    chk("R8 err after discard", err, 1);
    step();
    @(negedge clk);
    chk("R8 err clears", err, 0);
    chk("R8 no output", mon_n, n0);
    step();
  endtask

  task automatic t_mismatch();
    int n0 = mon_n;
    in_valid = '1; in_rx = '1; in_bin = {4'd9, 4'd3, 4'd3, 4'd3};
    @(negedge clk);
    chk("R7 mismatched stream dropped", in_ready, 4'b1000);
    step(); in_valid = '0;
    in_valid = 4'b0111; in_bin = '0;
    @(negedge clk);
    chk("R6 wait for all streams", in_ready, 4'b0000);
    step(); in_valid = '0;
    drain();
    chk("R6 R7 no output", mon_n, n0);
  endtask

  initial begin
    int h;
    t_reset();
    t_frames();
    t_bad_item();
    t_mismatch();
    // phase must still be at the first item of a bin (R6 R7 R8)
    send_bins(4, 0, 15);
    drain();
    check_frame(4, 1, 96, "R6 frame4", h);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule